// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side transmitter of a time-division multiplexed audio serial link. It runs on the link's bit clock, nominally 12.288 MHz, which gives one 256-bit frame every 20.8 µs (a 48 kHz sample rate). In every frame it raises a sync pulse, sends a 16-bit tag slot of valid flags, and then sends twelve 20-bit data slots on a single serial data line, most significant bit first.

The payload comes from parallel inputs: a codec register command (read flag, 7-bit address, 16-bit write data), a left and a right 20-bit playback sample, a 20-bit general-purpose I/O word and one valid flag per data slot. Whenever a frame begins, the block takes a snapshot of all of these inputs. Input changes during a frame therefore appear only in the next frame. A one-cycle `frame_start` strobe marks the first bit of each frame, so upstream logic can line up its sample updates with the frame boundary.

Top module: `link_frame_tx`

## Requirements
- R1: While `rst` is high, `link_sync`, `link_sdata` and `frame_start` are low. The first frame starts on the first rising clock edge after `rst` falls, so after that edge `frame_start` and `link_sync` are high and `link_sdata` carries frame bit position 0.
- R2: Each frame is exactly 256 clock cycles long. `frame_start` is high only for the single cycle in which bit position 0 is on `link_sdata`.
- R3: `link_sync` is high for bit positions 0 to 15 (the tag slot) and low for positions 16 to 255.
- R4: Tag slot layout, by bit position: position 0 is the frame-valid bit, equal to the OR of all twelve `slot_valid` bits. Position k (k = 1..12) equals `slot_valid[k-1]`, the flag of data slot k. Positions 13 to 15 are zero.
- R5: Data slot k occupies positions 16+20*(k-1) to 35+20*(k-1), MSB first. Slot 1 carries the command: its first bit is `cmd_rd` (1 = read), the next 7 bits are `cmd_addr` MSB first, and the last 12 bits are zero.
- R6: Slot 2 carries `cmd_wdata` MSB first in its first 16 bits, followed by 4 zero bits.
- R7: Slot 3 carries `pcm_left` and slot 4 carries `pcm_right`, all 20 bits each, MSB first.
- R8: Slot 12 carries `gpio_bits`, all 20 bits, MSB first.
- R9: A data slot whose `slot_valid` flag is clear is sent as 20 zero bits. Slots 5 to 11 have no payload source and are always sent as zeros.
- R10: All payload and valid inputs are sampled only at the clock edge that starts a frame. An input change during a frame has no effect on that frame and appears in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd | input | 1 | Command read flag (1 = read, 0 = write) |
| cmd_addr | input | 7 | Codec register address |
| cmd_wdata | input | 16 | Codec register write data |
| pcm_left | input | 20 | Left playback sample |
| pcm_right | input | 20 | Right playback sample |
| gpio_bits | input | 20 | General-purpose I/O word for slot 12 |
| slot_valid | input | 12 | Valid flag per data slot; bit k-1 belongs to slot k |
| link_sync | output | 1 | Frame sync, high during the tag slot |
| link_sdata | output | 1 | Serial frame data, MSB first |
| frame_start | output | 1 | One-cycle strobe on bit position 0 of each frame |

## Verification
The bound checker follows the frame timing on every cycle with its own position counter. It checks the 256-cycle frame period, the single-cycle strobe, the 16-cycle sync window, the zero padding at the end of the tag slot, and the zero bits of payload-less slots 5 to 11. Field contents cannot be checked this way: the placement of the command, write data, samples and GPIO word, the gating of invalid slots, and the rule that inputs are taken only at the frame boundary are shown by the bench's scenarios. The bench deserialises whole frames and compares each field with values it computes from the applied inputs, including one frame during which the inputs change partway through.

// File: rtl/link_frame_pkg.sv
package link_frame_pkg;

    // Frame geometry
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int POS_W     = $clog2(FRAME_W);

    // Payload widths
    localparam int ADDR_W  = 7;
    localparam int WDATA_W = 16;
    localparam int PCM_W   = SLOT_W;
    localparam int GPIO_W  = SLOT_W;

    // Slot numbers that carry a payload
    localparam int SLOT_CMD   = 1;
    localparam int SLOT_WDATA = 2;
    localparam int SLOT_LEFT  = 3;
    localparam int SLOT_RIGHT = 4;
    localparam int SLOT_GPIO  = 12;

    typedef enum logic [2:0] {
        ROLE_CMD,
        ROLE_WDATA,
        ROLE_LEFT,
        ROLE_RIGHT,
        ROLE_GPIO,
        ROLE_NONE
    } slot_role_e;

    typedef struct packed {
        logic               rd;
        logic [ADDR_W-1:0]  addr;
        logic [WDATA_W-1:0] wdata;
    } cmd_t;

    typedef struct packed {
        cmd_t                 cmd;
        logic [PCM_W-1:0]     left;
        logic [PCM_W-1:0]     right;
        logic [GPIO_W-1:0]    gpio;
        logic [NUM_SLOTS-1:0] valid;
    } frame_src_t;

    // Which payload a data slot carries
    function automatic slot_role_e role_of(input int k);
        case (k)
            SLOT_CMD:   return ROLE_CMD;
            SLOT_WDATA: return ROLE_WDATA;
            SLOT_LEFT:  return ROLE_LEFT;
            SLOT_RIGHT: return ROLE_RIGHT;
            SLOT_GPIO:  return ROLE_GPIO;
            default:    return ROLE_NONE;
        endcase
    endfunction

    // Index in the frame vector of the first (MSB) bit of data slot k.
    // Frame vector bit FRAME_W-1 is sent first.
    function automatic int slot_msb(input int k);
        return FRAME_W - 1 - TAG_W - SLOT_W * (k - 1);
    endfunction

endpackage

// File: rtl/link_frame_timer.sv
module link_frame_timer
    import link_frame_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_W,
    parameter int SYNC_LEN  = TAG_W,
    localparam int PW       = $clog2(FRAME_LEN)
) (
    input  logic clk,
    input  logic rst,
    output logic load,
    output logic sync,
    output logic start
);

    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
    localparam logic [PW-1:0] SYNC_END = PW'(SYNC_LEN);

    // Bit position currently on the serial line; reset to the last position
    // so that the first edge after reset opens a new frame.
    logic [PW-1:0] pos;
    logic [PW-1:0] pos_nxt;
    logic          wrap;

    always_comb begin
        wrap    = (pos == LAST_POS);
        pos_nxt = wrap ? '0 : pos + 1'b1;
    end

    assign load = wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= LAST_POS;
            sync  <= 1'b0;
            start <= 1'b0;
        end else begin
            pos   <= pos_nxt;
            sync  <= (pos_nxt < SYNC_END);
            start <= wrap;
        end
    end

endmodule

// File: rtl/link_frame_builder.sv
module link_frame_builder
    import link_frame_pkg::*;
(
    input  frame_src_t         src,
    output logic [FRAME_W-1:0] frame
);

    localparam int PAD_W = TAG_W - NUM_SLOTS - 1;

    // Tag slot: frame-valid bit, one flag per data slot, then padding
    assign frame[FRAME_W-1] = |src.valid;
    assign frame[FRAME_W-2-NUM_SLOTS -: PAD_W] = '0;

    for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_slot
        localparam slot_role_e ROLE = role_of(k);
        localparam int         MSB  = slot_msb(k);

        logic [SLOT_W-1:0] raw;

        if (ROLE == ROLE_CMD) begin : g_cmd
            assign raw = {src.cmd.rd, src.cmd.addr, {(SLOT_W-1-ADDR_W){1'b0}}};
        end else if (ROLE == ROLE_WDATA) begin : g_wdata
            assign raw = {src.cmd.wdata, {(SLOT_W-WDATA_W){1'b0}}};
        end else if (ROLE == ROLE_LEFT) begin : g_left
            assign raw = src.left;
        end else if (ROLE == ROLE_RIGHT) begin : g_right
            assign raw = src.right;
        end else if (ROLE == ROLE_GPIO) begin : g_gpio
            assign raw = src.gpio;
        end else begin : g_none
            assign raw = '0;
        end

        assign frame[FRAME_W-1-k]  = src.valid[k-1];
        assign frame[MSB -: SLOT_W] = src.valid[k-1] ? raw : '0;
    end

endmodule

// File: rtl/link_frame_shifter.sv
module link_frame_shifter
    import link_frame_pkg::*;
#(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] frame_in,
    output logic             sdata
);

    logic [WIDTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sdata <= 1'b0;
        end else if (load) begin
            sdata <= frame_in[WIDTH-1];
            shreg <= {frame_in[WIDTH-2:0], 1'b0};
        end else begin
            sdata <= shreg[WIDTH-1];
            shreg <= {shreg[WIDTH-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/link_frame_tx.sv
module link_frame_tx
    import link_frame_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_rd,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WDATA_W-1:0]   cmd_wdata,
    input  logic [PCM_W-1:0]     pcm_left,
    input  logic [PCM_W-1:0]     pcm_right,
    input  logic [GPIO_W-1:0]    gpio_bits,
    input  logic [NUM_SLOTS-1:0] slot_valid,
    output logic                 link_sync,
    output logic                 link_sdata,
    output logic                 frame_start
);

    frame_src_t         src;
    logic [FRAME_W-1:0] frame_vec;
    logic               load;

    always_comb begin
        src.cmd.rd    = cmd_rd;
        src.cmd.addr  = cmd_addr;
        src.cmd.wdata = cmd_wdata;
        src.left      = pcm_left;
        src.right     = pcm_right;
        src.gpio      = gpio_bits;
        src.valid     = slot_valid;
    end

    link_frame_timer #(
        .FRAME_LEN (FRAME_W),
        .SYNC_LEN  (TAG_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .sync  (link_sync),
        .start (frame_start)
    );

    link_frame_builder u_builder (
        .src   (src),
        .frame (frame_vec)
    );

    link_frame_shifter #(
        .WIDTH (FRAME_W)
    ) u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (frame_vec),
        .sdata    (link_sdata)
    );

endmodule

// File: rtl/link_frame_tx_chk.sv
module link_frame_tx_chk
    import link_frame_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic link_sync,
    input logic link_sdata,
    input logic frame_start
);

    localparam logic [POS_W-1:0] LAST_CNT  = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] SYNC_CNT  = POS_W'(TAG_W - 1);
    localparam logic [POS_W-1:0] PAD_LO    = POS_W'(NUM_SLOTS);
    localparam logic [POS_W-1:0] GAP_LO    = POS_W'(TAG_W + SLOT_W * SLOT_RIGHT - 1);
    localparam logic [POS_W-1:0] GAP_HI    = POS_W'(TAG_W + SLOT_W * (SLOT_GPIO - 1) - 2);

    // cnt + 1 is the bit position on the line whenever frame_start is low
    logic [POS_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (frame_start) begin
            cnt  <= '0;
            seen <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (frame_start && seen) |-> (cnt == LAST_CNT)); // R2

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R2

    AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> link_sync); // R3

    AST_SYNC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (seen && !frame_start) |-> (link_sync == (cnt < SYNC_CNT))); // R3

    AST_SYNC_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        link_sync |-> (seen || frame_start)); // R1

    AST_TAG_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (seen && !frame_start && cnt >= PAD_LO && cnt < SYNC_CNT) |-> !link_sdata); // R4

    AST_EMPTY_SLOTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (seen && !frame_start && cnt >= GAP_LO && cnt <= GAP_HI) |-> !link_sdata); // R9

endmodule

bind link_frame_tx link_frame_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_sync   (link_sync),
    .link_sdata  (link_sdata),
    .frame_start (frame_start)
);

// File: tb/link_frame_tx_tb.sv
module link_frame_tx_tb;

    typedef struct packed {
        logic        rd;
        logic [6:0]  addr;
        logic [15:0] wd;
        logic [19:0] l;
        logic [19:0] r;
        logic [19:0] g;
        logic [11:0] v;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_rd = 1'b0;
    logic [6:0]  cmd_addr = '0;
    logic [15:0] cmd_wdata = '0;
    logic [19:0] pcm_left = '0;
    logic [19:0] pcm_right = '0;
    logic [19:0] gpio_bits = '0;
    logic [11:0] slot_valid = '0;
    logic        link_sync;
    logic        link_sdata;
    logic        frame_start;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    link_frame_tx u_dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_rd      (cmd_rd),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .pcm_left    (pcm_left),
        .pcm_right   (pcm_right),
        .gpio_bits   (gpio_bits),
        .slot_valid  (slot_valid),
        .link_sync   (link_sync),
        .link_sdata  (link_sdata),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input stim_t s);
        cmd_rd     = s.rd;
        cmd_addr   = s.addr;
        cmd_wdata  = s.wd;
        pcm_left   = s.l;
        pcm_right  = s.r;
        gpio_bits  = s.g;
        slot_valid = s.v;
    endtask

    // Expected 256-bit frame; bit 255 is position 0 on the line
    function automatic logic [255:0] exp_frame(input stim_t s);
        logic [255:0] f = '0;
        f[255] = |s.v;
        for (int k = 1; k <= 12; k++) f[255-k] = s.v[k-1];
        for (int k = 1; k <= 12; k++) begin
            logic [19:0] p = '0;
            if (k == 1)  p = {s.rd, s.addr, 12'h000};
            if (k == 2)  p = {s.wd, 4'h0};
            if (k == 3)  p = s.l;
            if (k == 4)  p = s.r;
            if (k == 12) p = s.g;
            if (!s.v[k-1]) p = '0;
            f[255-16-20*(k-1) -: 20] = p;
        end
        return f;
    endfunction

    function automatic logic [19:0] slot_of(input logic [255:0] f, input int k);
        return f[255-16-20*(k-1) -: 20];
    endfunction

    // Capture one frame starting at the next frame_start; optionally swap
    // the inputs partway through the frame.
    task automatic grab(output logic [255:0] f, input bit swap, input stim_t nxt);
        int bad_sync = 0;
        int bad_fs = 0;
        while (frame_start !== 1'b1) @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            f[255-i] = link_sdata;
            if (link_sync !== (i < 16)) bad_sync++;
            if (i > 0 && frame_start !== 1'b0) bad_fs++;
            if (swap && i == 100) apply(nxt);
            @(negedge clk);
        end
        chk(bad_sync == 0, "R3 sync window", 64'(bad_sync), 64'd0);
        chk(bad_fs == 0 && frame_start === 1'b1, "R2 frame period", 64'(bad_fs), 64'd0);
    endtask

    task automatic compare(input logic [255:0] f, input stim_t s, input string tag);
        logic [255:0] e = exp_frame(s);
        chk(f[255 -: 16] == e[255 -: 16], {"R4 tag ", tag}, 64'(f[255 -: 16]), 64'(e[255 -: 16]));
        chk(slot_of(f, 1) == slot_of(e, 1), {"R5 cmd slot ", tag}, 64'(slot_of(f, 1)), 64'(slot_of(e, 1)));
        chk(slot_of(f, 2) == slot_of(e, 2), {"R6 wdata slot ", tag}, 64'(slot_of(f, 2)), 64'(slot_of(e, 2)));
        chk({slot_of(f, 3), slot_of(f, 4)} == {slot_of(e, 3), slot_of(e, 4)}, {"R7 pcm slots ", tag},
            64'({slot_of(f, 3), slot_of(f, 4)}), 64'({slot_of(e, 3), slot_of(e, 4)}));
        chk(slot_of(f, 12) == slot_of(e, 12), {"R8 gpio slot ", tag}, 64'(slot_of(f, 12)), 64'(slot_of(e, 12)));
        chk(f[159:20] == '0, {"R9 empty slots 5-11 ", tag}, 64'(f[159:20] != '0), 64'd0);
    endtask

    localparam stim_t P_ALL  = '{rd:1'b0, addr:7'h2A, wd:16'hBEEF, l:20'hA5C3F, r:20'h0F0F1, g:20'h80001, v:12'hFFF};
    localparam stim_t P_SOME = '{rd:1'b1, addr:7'h7F, wd:16'h1234, l:20'hFFFFF, r:20'h12345, g:20'h00003, v:12'h805};
    localparam stim_t P_NONE = '{rd:1'b1, addr:7'h55, wd:16'hFFFF, l:20'h77777, r:20'h88888, g:20'hFFFFF, v:12'h000};
    localparam stim_t P_A    = '{rd:1'b1, addr:7'h01, wd:16'h8001, l:20'h80000, r:20'h00001, g:20'h5A5A5, v:12'h80F};
    localparam stim_t P_B    = '{rd:1'b0, addr:7'h40, wd:16'h7FFE, l:20'h3C3C3, r:20'hC3C3C, g:20'hA5A5A, v:12'h80B};

    task automatic t_reset_and_first;
        logic [255:0] f;
        repeat (4) @(negedge clk);
        chk(link_sync === 1'b0 && link_sdata === 1'b0 && frame_start === 1'b0, "R1 reset outputs low",
            64'({link_sync, link_sdata, frame_start}), 64'd0);
        apply(P_ALL);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_start === 1'b1 && link_sync === 1'b1 && link_sdata === exp_frame(P_ALL)[255],
            "R1 first frame after reset", 64'({frame_start, link_sync, link_sdata}), 64'b111);
        grab(f, 1'b0, P_ALL);
        compare(f, P_ALL, "all valid");
    endtask

    task automatic t_pattern(input stim_t s, input string tag);
        logic [255:0] f;
        @(negedge clk);
        apply(s);
        grab(f, 1'b0, s);
        compare(f, s, tag);
    endtask

    task automatic t_latch;
        logic [255:0] f;
        @(negedge clk);
        apply(P_A);
        grab(f, 1'b1, P_B);
        chk(f == exp_frame(P_A), "R10 mid-frame change ignored", 64'(f[255:192]), 64'(exp_frame(P_A)[255:192]));
        grab(f, 1'b0, P_B);
        chk(f == exp_frame(P_B), "R10 change seen next frame", 64'(f[255:192]), 64'(exp_frame(P_B)[255:192]));
        compare(f, P_B, "after latch");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        t_reset_and_first();
        t_pattern(P_SOME, "partial valid");
        t_pattern(P_NONE, "none valid");
        t_latch();
        finish_run();
    end

endmodule